// File: doc/BRIEF.md
# Row-Strobe Cycle Decoder with Write Mask

This block sits behind the strobe pins of a multiport dynamic memory and works out what kind of cycle each row-strobe-low period is. At the falling edge of the active-low row strobe it looks at four control levels: column strobe, transfer/output-enable, write enable and serial enable. From them it picks one of six cycle types: refresh, three kinds of row/serial transfer, a normal read/write cycle and a masked-write cycle. It holds that choice until the row strobe rises again. At the same edge it takes the data pins as a per-bit write mask and captures the row address.

While the row strobe stays low, every falling edge of the column strobe starts a column access. Several such accesses in one row are page mode. For each access the block captures the column address and decides between read and write. A write enable that is already low at the column-strobe fall gives an early write. A write-enable fall during the access gives a late write. Each write leaves as a single-cycle pulse with a per-bit write-enable vector, and in masked mode only the bits chosen at the row-strobe fall are enabled. All strobes are sampled in the system clock domain through one register stage, and the results appear one clock after that stage.

Top module: `row_cycle_decoder`

## Requirements
- R1: If the column strobe is low when the row-strobe fall is sampled, the cycle is refresh (cycleType 6), whatever the other controls are.
- R2: With column strobe high and transfer/output-enable low at the row-strobe fall, the cycle is decoded as follows. Write enable high gives read transfer (3). Write enable low with serial enable low gives write transfer (4). Write enable low with serial enable high gives pseudo transfer (5).
- R3: With column strobe high and transfer/output-enable high at the row-strobe fall, write enable high gives a normal read/write cycle (1) and write enable low gives a masked-write cycle (2).
- R4: The decoded type appears two clock edges after the row strobe is driven low, together with rowActive and a cycleStart pulse one clock wide. It stays fixed while the row strobe is low, whatever the other pins do. Two edges after the row strobe rises, cycleType returns to idle (0) and rowActive to 0.
- R5: At the row-strobe fall, data pin i becomes mask bit i; 1 enables writes to bit i and 0 blocks them. In a normal read/write cycle every bit is enabled, so bitWriteEn is all ones on each write.
- R6: The mask latched at the row-strobe fall applies to every column access of that row cycle, including page-mode accesses. Data-pin changes during the row cycle do not alter it.
- R7: The row address is captured at the row-strobe fall. At each column-strobe fall in a non-refresh cycle, the column address is captured and colStart pulses for one clock. All 2^ADDR_W column values can be reached within one row cycle.
- R8: Early write: if write enable is low at the column-strobe fall, one write pulse (wrPulse) is issued with the data sampled at that fall. dataOutEn stays 0 for the whole access.
- R9: Late write: a write-enable fall while the column strobe is low, in an access that has not yet written, issues one write pulse with the data sampled at that fall. Further write-enable falls in the same access issue nothing.
- R10: dataOutEn is 1 only during a column access of a read/write or masked-write cycle, with write enable high and transfer/output-enable low, and only when the access is not an early write.
- R11: Column accesses in refresh and transfer cycles never produce a write pulse, and bitWriteEn stays 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rowStrobeN | input | 1 | Row strobe, active low |
| colStrobeN | input | 1 | Column strobe, active low |
| xferOeN | input | 1 | Transfer select at the row-strobe fall, output enable afterwards (active low) |
| writeEnN | input | 1 | Write enable, active low; selects the mode at the row-strobe fall |
| serialEnN | input | 1 | Serial enable, active low |
| addrIn | input | ADDR_W | Multiplexed row/column address |
| dataIn | input | DATA_W | Data pins; mask bits at the row-strobe fall, write data afterwards |
| cycleType | output | 3 | Decoded cycle: 0 idle, 1 read/write, 2 masked write, 3 read transfer, 4 write transfer, 5 pseudo transfer, 6 refresh |
| cycleStart | output | 1 | One-clock pulse when a new cycle type is latched |
| rowActive | output | 1 | High while a row cycle is in progress |
| rowAddr | output | ADDR_W | Row address captured at the row-strobe fall |
| colAddr | output | ADDR_W | Column address of the latest column access |
| colStart | output | 1 | One-clock pulse per column access |
| wrPulse | output | 1 | One-clock write command to the array |
| bitWriteEn | output | DATA_W | Per-bit write enables, valid with wrPulse, zero otherwise |
| wrData | output | DATA_W | Write data for the latest write pulse |
| dataOutEn | output | 1 | Read data output enable |

## Verification
The bench uses the default configuration: a 9-bit address, so columns 0 to 511 lie within reach, and a 4-bit data path, so the full mask space has 16 values. It sweeps all 16 combinations of the four control levels at the row-strobe fall against all 16 data-pin patterns. In each of the 256 row cycles it checks the decoded type, the latched row address, that the cycle is held when pins change, and the result of one early-write column access. A separate masked page-mode row covers reads with the output enable on and off, a late write, a repeated write-enable fall, and accesses at the highest column address.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_RW      = 3'd1,
    CYC_MASKWR  = 3'd2,
    CYC_RDXFER  = 3'd3,
    CYC_WRXFER  = 3'd4,
    CYC_PSXFER  = 3'd5,
    CYC_REFRESH = 3'd6
  } cycle_e;

  // strobes from control to datapath, all valid in the same clock
  typedef struct packed {
    logic rowLatch;   // row strobe fall seen: capture row address and mask
    logic maskMode;   // write enable was low at that fall
    logic colLatch;   // column access begins: capture column address
    logic writeGo;    // issue one write this clock
  } ctlStrobe_t;

  // levels are the sampled pin levels (1 = high) at the row strobe fall
  function automatic cycle_e decodeCycle(input logic colLvl, input logic xferLvl,
                                         input logic weLvl, input logic seLvl);
    cycle_e res;
    if (!colLvl)
      res = CYC_REFRESH;
    else if (!xferLvl) begin
      if (weLvl)
        res = CYC_RDXFER;
      else if (seLvl)
        res = CYC_PSXFER;
      else
        res = CYC_WRXFER;
    end else if (weLvl)
      res = CYC_RW;
    else
      res = CYC_MASKWR;
    return res;
  endfunction

endpackage

// File: rtl/rcd_control.sv
module rcd_control
  import rcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowStrobeN,
  input  logic       colStrobeN,
  input  logic       xferOeN,
  input  logic       writeEnN,
  input  logic       serialEnN,
  output ctlStrobe_t ctl,
  output cycle_e     cycleType,
  output logic       cycleStart,
  output logic       rowActive,
  output logic       colStart,
  output logic       dataOutEn
);

  // sampled pin levels and their previous samples
  logic sRow, sCol, sXfer, sWe, sSe;
  logic pRow, pCol, pWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sRow  <= 1'b1;
      sCol  <= 1'b1;
      sXfer <= 1'b1;
      sWe   <= 1'b1;
      sSe   <= 1'b1;
      pRow  <= 1'b1;
      pCol  <= 1'b1;
      pWe   <= 1'b1;
    end else begin
      sRow  <= rowStrobeN;
      sCol  <= colStrobeN;
      sXfer <= xferOeN;
      sWe   <= writeEnN;
      sSe   <= serialEnN;
      pRow  <= sRow;
      pCol  <= sCol;
      pWe   <= sWe;
    end
  end

  cycle_e cycleQ;
  logic   colActive, earlyWr, wrDone;

  logic rowFall, rowRise, rowLive, rwCycle;
  logic colFall, colRise, weFall, earlyGo, lateGo;

  always_comb begin
    rowFall = pRow & ~sRow;
    rowRise = ~pRow & sRow;
    rowLive = rowActive & ~rowRise;
    rwCycle = rowLive & ((cycleQ == CYC_RW) || (cycleQ == CYC_MASKWR));
    colFall = pCol & ~sCol & rowLive & (cycleQ != CYC_REFRESH);
    colRise = ~pCol & sCol;
    weFall  = pWe & ~sWe;
    earlyGo = colFall & rwCycle & ~sWe;
    lateGo  = colActive & ~sCol & rwCycle & ~wrDone & weFall;
  end

  always_comb begin
    ctl.rowLatch = rowFall;
    ctl.maskMode = ~sWe;
    ctl.colLatch = colFall;
    ctl.writeGo  = earlyGo | lateGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleQ     <= CYC_IDLE;
      rowActive  <= 1'b0;
      cycleStart <= 1'b0;
      colStart   <= 1'b0;
      colActive  <= 1'b0;
      earlyWr    <= 1'b0;
      wrDone     <= 1'b0;
    end else begin
      cycleStart <= rowFall;
      colStart   <= colFall;
      if (rowFall) begin
        cycleQ    <= decodeCycle(sCol, sXfer, sWe, sSe);
        rowActive <= 1'b1;
      end else if (rowRise) begin
        cycleQ    <= CYC_IDLE;
        rowActive <= 1'b0;
      end
      if (rowFall || rowRise)
        colActive <= 1'b0;
      else if (colFall)
        colActive <= 1'b1;
      else if (colRise)
        colActive <= 1'b0;
      if (colFall)
        earlyWr <= ~sWe;
      if (rowFall || rowRise || colRise)
        wrDone <= 1'b0;
      else if (ctl.writeGo)
        wrDone <= 1'b1;
    end
  end

  always_comb begin
    cycleType = cycleQ;
    dataOutEn = colActive & rwCycle & ~earlyWr & ~sXfer & sWe;
  end

  // R4: the start marker never lasts two clocks
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart);

  // R4: the cycle type holds for the whole row-low period
  a_r4_hold_type: assert property (@(posedge clk) disable iff (!rstN)
    (rowActive && $past(rowActive)) |-> (cycleQ == $past(cycleQ)));

  // R4: outside a row cycle the type reads idle
  a_r4_idle_off: assert property (@(posedge clk) disable iff (!rstN)
    !rowActive |-> (cycleQ == CYC_IDLE));

  // R1: refresh cycles carry no column accesses
  a_r1_refresh_no_col: assert property (@(posedge clk) disable iff (!rstN)
    (cycleQ == CYC_REFRESH) |-> !colStart);

  // R8: an early-write access never drives read data
  a_r8_early_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (colStart && earlyWr) |-> !dataOutEn);

endmodule

// File: rtl/rcd_datapath.sv
module rcd_datapath
  import rcd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  ctlStrobe_t        ctl,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              wrPulse,
  output logic [DATA_W-1:0] bitWriteEn,
  output logic [DATA_W-1:0] wrData
);

  localparam logic [DATA_W-1:0] MASK_ALL = {DATA_W{1'b1}};

  logic [ADDR_W-1:0] sAddr;
  logic [DATA_W-1:0] sData;
  logic [DATA_W-1:0] mask;

  // sample stage aligned with the control sample stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sAddr <= '0;
      sData <= '0;
    end else begin
      sAddr <= addrIn;
      sData <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAddr <= '0;
      colAddr <= '0;
      mask    <= MASK_ALL;
      wrPulse <= 1'b0;
      wrData  <= '0;
    end else begin
      if (ctl.rowLatch) begin
        rowAddr <= sAddr;
        mask    <= ctl.maskMode ? sData : MASK_ALL;
      end
      if (ctl.colLatch)
        colAddr <= sAddr;
      wrPulse <= ctl.writeGo;
      if (ctl.writeGo)
        wrData <= sData;
    end
  end

  // one enable flop per data bit
  for (genvar b = 0; b < DATA_W; b++) begin : g_bitEn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bitWriteEn[b] <= 1'b0;
      else
        bitWriteEn[b] <= ctl.writeGo & mask[b];
    end
  end

  // R6: the mask changes only on a row strobe fall
  a_r6_mask_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rowLatch |=> $stable(mask));

  // R7: the column address changes only at a column access
  a_r7_col_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.colLatch |=> $stable(colAddr));

  // R11: enables are only ever raised together with a write
  a_r11_en_with_write: assert property (@(posedge clk) disable iff (!rstN)
    (bitWriteEn != '0) |-> wrPulse);

endmodule

// File: rtl/row_cycle_decoder.sv
module row_cycle_decoder
  import rcd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStrobeN,
  input  logic              colStrobeN,
  input  logic              xferOeN,
  input  logic              writeEnN,
  input  logic              serialEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [2:0]        cycleType,
  output logic              cycleStart,
  output logic              rowActive,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              colStart,
  output logic              wrPulse,
  output logic [DATA_W-1:0] bitWriteEn,
  output logic [DATA_W-1:0] wrData,
  output logic              dataOutEn
);

  ctlStrobe_t ctl;
  cycle_e     cycleEnum;

  rcd_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rowStrobeN (rowStrobeN),
    .colStrobeN (colStrobeN),
    .xferOeN    (xferOeN),
    .writeEnN   (writeEnN),
    .serialEnN  (serialEnN),
    .ctl        (ctl),
    .cycleType  (cycleEnum),
    .cycleStart (cycleStart),
    .rowActive  (rowActive),
    .colStart   (colStart),
    .dataOutEn  (dataOutEn)
  );

  rcd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .addrIn     (addrIn),
    .dataIn     (dataIn),
    .ctl        (ctl),
    .rowAddr    (rowAddr),
    .colAddr    (colAddr),
    .wrPulse    (wrPulse),
    .bitWriteEn (bitWriteEn),
    .wrData     (wrData)
  );

  assign cycleType = cycleEnum;

  // R11: writes only happen in read/write or masked-write cycles
  a_r11_write_kind: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> (cycleType == 3'd1 || cycleType == 3'd2));

  // R5: a normal-mode write enables every bit
  a_r5_normal_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrPulse && cycleType == 3'd1) |-> (bitWriteEn == {DATA_W{1'b1}}));

  // R9: never two write pulses back to back
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  // R10: read data is driven only inside a row cycle
  a_r10_out_in_row: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> rowActive);

endmodule

// File: tb/sim_row_cycle_decoder.sv
module sim_row_cycle_decoder;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rowStrobeN, colStrobeN, xferOeN, writeEnN, serialEnN;
  logic [ADDR_W-1:0] addrIn;
  logic [DATA_W-1:0] dataIn;
  logic [2:0]        cycleType;
  logic              cycleStart, rowActive, colStart, wrPulse, dataOutEn;
  logic [ADDR_W-1:0] rowAddr, colAddr;
  logic [DATA_W-1:0] bitWriteEn, wrData;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  row_cycle_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .xferOeN(xferOeN), .writeEnN(writeEnN), .serialEnN(serialEnN),
    .addrIn(addrIn), .dataIn(dataIn), .cycleType(cycleType),
    .cycleStart(cycleStart), .rowActive(rowActive), .rowAddr(rowAddr),
    .colAddr(colAddr), .colStart(colStart), .wrPulse(wrPulse),
    .bitWriteEn(bitWriteEn), .wrData(wrData), .dataOutEn(dataOutEn)
  );

  task automatic check(input int act, input int exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycle code from the requirement tables; c = {col, xfer, we, se} levels
  function automatic int expCycle(input int c);
    int col, xf, we, se;
    col = (c >> 3) & 1;
    xf  = (c >> 2) & 1;
    we  = (c >> 1) & 1;
    se  = c & 1;
    if (col == 0) return 6;
    if (xf == 0) return (we == 1) ? 3 : ((se == 1) ? 5 : 4);
    return (we == 1) ? 1 : 2;
  endfunction

  initial begin
    #(CLK_P * 150000);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    rowStrobeN = 1'b1; colStrobeN = 1'b1; xferOeN = 1'b1;
    writeEnN = 1'b1; serialEnN = 1'b1; addrIn = '0; dataIn = '0;
    step(3);
    rstN = 1'b1;
    step(2);
    check(int'(cycleType), 0, "R4 reset type idle");
    check(int'(rowActive), 0, "R4 reset rowActive");
    check(int'(wrPulse), 0, "R11 reset wrPulse");
    check(int'(bitWriteEn), 0, "R11 reset bitWriteEn");
    check(int'(dataOutEn), 0, "R10 reset dataOutEn");

    // sweep every control combination against every data pattern
    for (int c = 0; c < 16; c++) begin
      for (int d = 0; d < 16; d++) begin
        int ec, ra, ca, wd;
        ec = expCycle(c);
        ra = c * 32 + d;
        ca = 511 - ra;
        wd = (d * 7 + 3) & 15;
        colStrobeN = c[3]; xferOeN = c[2]; writeEnN = c[1]; serialEnN = c[0];
        dataIn = d[DATA_W-1:0];
        addrIn = ra[ADDR_W-1:0];
        rowStrobeN = 1'b0;
        step(2);
        if (ec == 6) check(int'(cycleType), ec, "R1 refresh decode");
        else if (ec >= 3) check(int'(cycleType), ec, "R2 transfer decode");
        else check(int'(cycleType), ec, "R3 rw/masked decode");
        check(int'(cycleStart), 1, "R4 cycleStart pulse");
        check(int'(rowActive), 1, "R4 rowActive set");
        check(int'(rowAddr), ra, "R7 row address");
        // disturb the mode pins and data; type must hold
        colStrobeN = 1'b1; xferOeN = ~c[2]; writeEnN = ~c[1]; serialEnN = ~c[0];
        dataIn = ~d[DATA_W-1:0];
        addrIn = '0;
        step(2);
        check(int'(cycleStart), 0, "R4 cycleStart one clock");
        check(int'(cycleType), ec, "R4 type held");
        // one early-write column access
        xferOeN = 1'b1; writeEnN = 1'b0;
        dataIn = wd[DATA_W-1:0];
        addrIn = ca[ADDR_W-1:0];
        colStrobeN = 1'b0;
        step(2);
        check(int'(dataOutEn), 0, "R8 early write output off");
        if (ec == 1) begin
          check(int'(wrPulse), 1, "R8 early write pulse");
          check(int'(bitWriteEn), 15, "R5 normal mode all bits");
          check(int'(wrData), wd, "R8 early write data");
        end else if (ec == 2) begin
          check(int'(wrPulse), 1, "R8 early write pulse masked");
          check(int'(bitWriteEn), d, "R5 mask from row fall");
          check(int'(wrData), wd, "R8 early write data masked");
        end else begin
          check(int'(wrPulse), 0, "R11 no write pulse");
          check(int'(bitWriteEn), 0, "R11 no enables");
        end
        if (ec != 6) begin
          check(int'(colStart), 1, "R7 colStart pulse");
          check(int'(colAddr), ca, "R7 column address");
        end
        step(1);
        check(int'(wrPulse), 0, "R9 single write");
        colStrobeN = 1'b1; writeEnN = 1'b1; rowStrobeN = 1'b1;
        step(2);
        check(int'(cycleType), 0, "R4 idle after row rise");
        check(int'(rowActive), 0, "R4 rowActive cleared");
      end
    end

    // masked page-mode row, mask 0101
    colStrobeN = 1'b1; xferOeN = 1'b1; writeEnN = 1'b0; serialEnN = 1'b1;
    dataIn = 4'h5; addrIn = 9'd77; rowStrobeN = 1'b0;
    step(2);
    check(int'(cycleType), 2, "R3 masked decode page");
    writeEnN = 1'b1; dataIn = 4'hF;
    addrIn = 9'd10; colStrobeN = 1'b0;
    step(2);
    check(int'(colAddr), 10, "R7 page access 1 column");
    check(int'(dataOutEn), 0, "R10 output enable high keeps output off");
    xferOeN = 1'b0;
    step(2);
    check(int'(dataOutEn), 1, "R10 read drives output");
    check(int'(wrPulse), 0, "R10 read issues no write");
    xferOeN = 1'b1;
    step(1);
    writeEnN = 1'b0; dataIn = 4'hA;
    step(2);
    check(int'(wrPulse), 1, "R9 late write pulse");
    check(int'(bitWriteEn), 5, "R6 mask on late write");
    check(int'(wrData), 10, "R9 late write data");
    check(int'(dataOutEn), 0, "R10 output off while writing");
    step(1);
    check(int'(wrPulse), 0, "R9 late write one clock");
    writeEnN = 1'b1;
    step(2);
    writeEnN = 1'b0;
    step(2);
    check(int'(wrPulse), 0, "R9 second fall ignored");
    colStrobeN = 1'b1; writeEnN = 1'b1;
    step(2);
    addrIn = 9'd300; writeEnN = 1'b0; dataIn = 4'h3; colStrobeN = 1'b0;
    step(2);
    check(int'(colAddr), 300, "R7 page access 2 column");
    check(int'(bitWriteEn), 5, "R6 mask on page access 2");
    check(int'(wrData), 3, "R8 page access 2 data");
    colStrobeN = 1'b1; writeEnN = 1'b1;
    step(2);
    addrIn = 9'd511; writeEnN = 1'b0; dataIn = 4'hC; colStrobeN = 1'b0;
    step(2);
    check(int'(colAddr), 511, "R7 top column");
    check(int'(bitWriteEn), 5, "R6 mask on page access 3");
    check(int'(rowAddr), 77, "R7 row address held");
    colStrobeN = 1'b1; writeEnN = 1'b1; rowStrobeN = 1'b1;
    step(2);
    check(int'(cycleType), 0, "R4 idle after page row");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule